// File: doc/BRIEF.md
# Audio Port Bit and Frame Clock Controller

This block owns the clock pins of a serial digital audio port that can run as clock master or as clock slave. In master mode it divides the system clock down to a bit clock and counts bit-clock falling edges to produce two frame clocks: one for playback and one for record. The two frame clocks share the bit clock but each has its own frame length, so the port can serve two sample rates. In slave mode all clock pins are inputs, and the block generates nothing and drives none of them.

A 16-bit control word, written through a plain strobe, holds four bits: the master select, a float-all bit that releases every output pin of the port, and two force bits. With every audio channel disabled, the force bits keep the clocks running. The full force keeps the bit clock and both frame clocks running. The frame-only force keeps the frame clocks running while the bit-clock pin stays low. The record frame clock leaves on a shared pin, which this block drives only when that pin's function select picks the record-frame role.

Generated clocks start and stop only on a common frame boundary, and the bit-clock divider is held in reset while the clocks are stopped. As a result a clock pin never shows a shortened high phase.

Top module: `aif_clk_ctrl`

## Requirements
- R1: After reset the control word is all zero (slave, not floated, no force). All three clock outputs are low, their output enables are low, and `sdout_oe` is high.
- R2: The control word is updated only on a clock edge with `ctl_wr` high. The fields are: bit 15 float-all, bit 14 master (1) or slave (0), bit 13 full clock force, bit 12 frame-only force. Bits 11..0 are ignored.
- R3: In slave mode the enables `bclk_oe`, `pbfrm_oe` and `recfrm_oe` stay low and no clock output toggles.
- R4: In master mode with at least one bit of `ch_en` set, `bclk_o` has a period of 2*BCLK_HALF system clocks with 50% duty. `pbfrm_o` has a period of PB_BCLKS bit clocks and `recfrm_o` a period of RC_BCLKS bit clocks, each high for the first half of its frame.
- R5: In master mode with no channel enabled and both force bits clear, all three clock outputs settle low and stay low.
- R6: In master mode the full clock force keeps the bit clock and both frame clocks running with all channels disabled.
- R7: In master mode the frame-only force keeps both frame clocks running with all channels disabled, while `bclk_o` stays low.
- R8: While float-all is set, every output enable of the port is low (`bclk_oe`, `pbfrm_oe`, `recfrm_oe`, `sdout_oe`), whatever the mode.
- R9: `recfrm_oe` is high only when `shared_pin_sel` is 1, master is set and float-all is clear. With `shared_pin_sel` at 0 it stays low, whatever float-all holds.
- R10: Generated clocks start and stop only on a boundary shared by both frames, and the bit-clock gate changes only on such a boundary. Every high phase of `bclk_o` lasts BCLK_HALF cycles, every high phase of `pbfrm_o` lasts PB_BCLKS*BCLK_HALF cycles, and every high phase of `recfrm_o` lasts RC_BCLKS*BCLK_HALF cycles. The number of bit clocks from a start to the following stop is a multiple of both frame lengths.
- R11: `sdout_oe` is the inverse of float-all, and in master mode `bclk_oe` and `pbfrm_oe` are its copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, source of the generated bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ch_en | input | NUM_CH | Enable of each audio channel of the port |
| shared_pin_sel | input | 1 | 1 when the shared pin's function is the record frame clock |
| bclk_o | output | 1 | Bit clock output value |
| bclk_oe | output | 1 | Bit clock pad output enable |
| pbfrm_o | output | 1 | Playback frame clock output value |
| pbfrm_oe | output | 1 | Playback frame clock pad output enable |
| recfrm_o | output | 1 | Record frame clock output value (shared pin) |
| recfrm_oe | output | 1 | Shared pin output enable in its record-frame role |
| sdout_oe | output | 1 | Serial data output pad enable |

## Verification
The hardest situation to reach is a stop or gate change requested in the middle of a frame. The block must hold off until the playback and record counters wrap together, and the ports give no sign of where that point lies. The stimulus turns the channels on, waits for an arbitrary time, then turns them off. Monitors watch every high phase of all three clocks for truncation, and the bench checks that the bit-clock edges counted between start and stop fill whole frames of both lengths. The configuration table also moves straight between full force, frame-only force and channel-driven running, so the gate changes happen in the middle of a frame.

// File: rtl/aif_clk_pkg.sv
package aif_clk_pkg;
  localparam int CTL_W     = 16;
  localparam int BIT_FLOAT = 15;
  localparam int BIT_MST   = 14;
  localparam int BIT_FCLK  = 13;
  localparam int BIT_FFRM  = 12;

  typedef struct packed {
    logic float_all;
    logic master;
    logic frc_clk;
    logic frc_frm;
  } ctl_t;
endpackage

// File: rtl/aif_ctl_reg.sv
module aif_ctl_reg
  import aif_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  logic unused_low_bits;
  assign unused_low_bits = ^wdata[BIT_FFRM-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr) begin
      ctl.float_all <= wdata[BIT_FLOAT];
      ctl.master    <= wdata[BIT_MST];
      ctl.frc_clk   <= wdata[BIT_FCLK];
      ctl.frc_frm   <= wdata[BIT_FFRM];
    end
  end
endmodule

// File: rtl/aif_bclk_gen.sv
module aif_bclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk_q,
  output logic fall
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [DW-1:0] div_q;
  logic          term;

  assign term = (div_q == DW'(HALF - 1));
  assign fall = run && term && bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (term) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/aif_frame_gen.sv
module aif_frame_gen #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic adv,
  output logic frm_q,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == CW'(LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      frm_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      frm_q <= 1'b1;
    end else if (stop) begin
      cnt_q <= '0;
      frm_q <= 1'b0;
    end else if (adv) begin
      if (last) begin
        cnt_q <= '0;
        frm_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        frm_q <= ((int'(cnt_q) + 1) < (LEN / 2));
      end
    end
  end
endmodule

// File: rtl/aif_pad_ctrl.sv
module aif_pad_ctrl (
  input  logic float_all,
  input  logic master,
  input  logic pin_sel,
  output logic bclk_oe,
  output logic pbfrm_oe,
  output logic recfrm_oe,
  output logic sdout_oe
);
  logic drive;
  assign drive     = master && !float_all;
  assign bclk_oe   = drive;
  assign pbfrm_oe  = drive;
  assign recfrm_oe = drive && pin_sel;
  assign sdout_oe  = !float_all;
endmodule

// File: rtl/aif_clk_ctrl.sv
module aif_clk_ctrl
  import aif_clk_pkg::*;
#(
  parameter int BCLK_HALF = 2,
  parameter int PB_BCLKS  = 8,
  parameter int RC_BCLKS  = 16,
  parameter int NUM_CH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              shared_pin_sel,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              pbfrm_o,
  output logic              pbfrm_oe,
  output logic              recfrm_o,
  output logic              recfrm_oe,
  output logic              sdout_oe
);
  ctl_t ctl;
  logic any_ch, want, start, stop, boundary;
  logic run_q, gate_q, bclk_q, fall;
  logic pb_frm, rc_frm, pb_last, rc_last;
  logic float_all, master;

  aif_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .ctl(ctl)
  );

  assign float_all = ctl.float_all;
  assign master    = ctl.master;
  assign any_ch    = |ch_en;
  assign want      = master && (any_ch || ctl.frc_clk || ctl.frc_frm);
  assign boundary  = fall && pb_last && rc_last;
  assign start     = !run_q && want;
  assign stop      = run_q && boundary && !want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      gate_q <= any_ch || ctl.frc_clk;
    end else if (stop) begin
      run_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (boundary) begin
      gate_q <= any_ch || ctl.frc_clk;
    end
  end

  aif_bclk_gen #(.HALF(BCLK_HALF)) u_bclk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .bclk_q(bclk_q), .fall(fall)
  );

  aif_frame_gen #(.LEN(PB_BCLKS)) u_pb (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .adv(fall),
    .frm_q(pb_frm), .last(pb_last)
  );

  aif_frame_gen #(.LEN(RC_BCLKS)) u_rc (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .adv(fall),
    .frm_q(rc_frm), .last(rc_last)
  );

  assign bclk_o   = bclk_q && gate_q;
  assign pbfrm_o  = pb_frm;
  assign recfrm_o = rc_frm;

  aif_pad_ctrl u_pad (
    .float_all(float_all), .master(master), .pin_sel(shared_pin_sel),
    .bclk_oe(bclk_oe), .pbfrm_oe(pbfrm_oe), .recfrm_oe(recfrm_oe),
    .sdout_oe(sdout_oe)
  );
endmodule

// File: rtl/aif_clk_ctrl_chk.sv
module aif_clk_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic float_all,
  input logic master,
  input logic shared_pin_sel,
  input logic run_q,
  input logic fall,
  input logic pb_last,
  input logic rc_last,
  input logic bclk_o,
  input logic pbfrm_o,
  input logic recfrm_o,
  input logic bclk_oe,
  input logic pbfrm_oe,
  input logic recfrm_oe,
  input logic sdout_oe
);
  a_r3_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!bclk_oe && !pbfrm_oe && !recfrm_oe));

  a_r8_float_all_oe: assert property (@(posedge clk) disable iff (!rst_n)
    float_all |-> (!bclk_oe && !pbfrm_oe && !recfrm_oe && !sdout_oe));

  a_r9_shared_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
    !shared_pin_sel |-> !recfrm_oe);

  a_r5_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!bclk_o && !pbfrm_o && !recfrm_o));

  a_r10_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(fall && pb_last && rc_last));

  a_r11_sdout_follows_float: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(float_all) |-> sdout_oe);
endmodule

bind aif_clk_ctrl aif_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .float_all(float_all), .master(master),
  .shared_pin_sel(shared_pin_sel), .run_q(run_q), .fall(fall),
  .pb_last(pb_last), .rc_last(rc_last), .bclk_o(bclk_o), .pbfrm_o(pbfrm_o),
  .recfrm_o(recfrm_o), .bclk_oe(bclk_oe), .pbfrm_oe(pbfrm_oe),
  .recfrm_oe(recfrm_oe), .sdout_oe(sdout_oe)
);

// File: tb/aif_clk_ctrl_tb.sv
module aif_clk_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int PB   = 8;
  localparam int RC   = 16;
  localparam int NCH  = 2;
  localparam int WIN  = 128;
  localparam int SETTLE = 160;
  localparam int NV   = 13;
  // fields: float,mst,fclk,ffrm | ch[1:0] | sel | exp bclk,pb,rc run | exp oe bclk,pb,rc,sdout
  localparam logic [0:NV-1][13:0] VECS = {
    14'b0000_00_1_000_0001,  // R3 slave idle
    14'b0000_11_1_000_0001,  // R3 slave with channels
    14'b0100_01_1_111_1111,  // R4 master, channel on
    14'b0100_00_1_000_1111,  // R5 master idle
    14'b0110_00_1_111_1111,  // R6 full force
    14'b0101_00_1_011_1111,  // R7 frame-only force
    14'b0101_00_0_011_1101,  // R9 shared pin other role
    14'b1100_10_1_111_0000,  // R8 floated master
    14'b1000_00_0_000_0000,  // R8 floated slave
    14'b0111_00_1_111_1111,  // R6 both forces
    14'b0101_10_0_111_1101,  // R7 frame force plus channel
    14'b0010_00_1_000_0001,  // R3 force in slave
    14'b1101_00_1_011_0000   // R8 floated frame force
  };

  logic clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0, shared_pin_sel = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [NCH-1:0] ch_en = '0;
  logic bclk_o, bclk_oe, pbfrm_o, pbfrm_oe, recfrm_o, recfrm_oe, sdout_oe;

  int checks = 0, fails = 0;
  int viol_b = 0, viol_p = 0, viol_r = 0, rises = 0;
  int len_b = 0, len_p = 0, len_r = 0;
  logic pb_prev = 0, pp_prev = 0, pr_prev = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aif_clk_ctrl #(.BCLK_HALF(HALF), .PB_BCLKS(PB), .RC_BCLKS(RC), .NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ch_en(ch_en),
    .shared_pin_sel(shared_pin_sel), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .pbfrm_o(pbfrm_o), .pbfrm_oe(pbfrm_oe), .recfrm_o(recfrm_o),
    .recfrm_oe(recfrm_oe), .sdout_oe(sdout_oe)
  );

  // R10 high-phase monitors, sampled on the falling system clock
  always @(negedge clk) begin
    if (!rst_n) begin
      len_b = 0; len_p = 0; len_r = 0;
      pb_prev = 0; pp_prev = 0; pr_prev = 0;
    end else begin
      if (bclk_o) len_b++;
      else if (pb_prev) begin if (len_b != HALF) viol_b++; len_b = 0; end
      if (bclk_o && !pb_prev) rises++;
      if (pbfrm_o) len_p++;
      else if (pp_prev) begin if (len_p != PB*HALF) viol_p++; len_p = 0; end
      if (recfrm_o) len_r++;
      else if (pr_prev) begin if (len_r != RC*HALF) viol_r++; len_r = 0; end
      pb_prev = bclk_o; pp_prev = pbfrm_o; pr_prev = recfrm_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] c, input logic [NCH-1:0] ch, input logic sel);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {c, 12'hA5C}; ch_en = ch; shared_pin_sel = sel;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 oe word", {bclk_oe, pbfrm_oe, recfrm_oe, sdout_oe}, 4'b0001);
    chk("R1 clocks", {bclk_o, pbfrm_o, recfrm_o}, 3'b000);

    for (int v = 0; v < NV; v++) begin
      int tb_, tp, tr, hp, hr;
      logic a, b, c;
      logic [13:0] e;
      e = VECS[v];
      set_cfg(e[13:10], e[9:8], e[7]);
      repeat (SETTLE) @(negedge clk);
      tb_ = 0; tp = 0; tr = 0; hp = 0; hr = 0;
      a = bclk_o; b = pbfrm_o; c = recfrm_o;
      for (int k = 0; k < WIN; k++) begin
        @(negedge clk);
        if (bclk_o != a) tb_++;
        if (pbfrm_o != b) tp++;
        if (recfrm_o != c) tr++;
        if (pbfrm_o) hp++;
        if (recfrm_o) hr++;
        a = bclk_o; b = pbfrm_o; c = recfrm_o;
      end
      chk($sformatf("R4/R5/R6/R7 vec%0d bclk toggles", v), tb_, e[6] ? WIN/HALF : 0);
      chk($sformatf("R4/R6/R7 vec%0d pbfrm toggles", v), tp, e[5] ? WIN/(PB*HALF) : 0);
      chk($sformatf("R4/R6/R7 vec%0d recfrm toggles", v), tr, e[4] ? WIN/(RC*HALF) : 0);
      chk($sformatf("R4 vec%0d pbfrm duty", v), hp, e[5] ? WIN/2 : 0);
      chk($sformatf("R4 vec%0d recfrm duty", v), hr, e[4] ? WIN/2 : 0);
      chk($sformatf("R3/R8/R9/R11 vec%0d oe word", v),
          {bclk_oe, pbfrm_oe, recfrm_oe, sdout_oe}, e[3:0]);
    end

    // R10 stop mid-frame waits for shared boundary
    set_cfg(4'b0100, 2'b00, 1'b1);
    repeat (200) @(negedge clk);
    r0 = rises;
    set_cfg(4'b0100, 2'b10, 1'b1);
    repeat (150) @(negedge clk);
    set_cfg(4'b0100, 2'b00, 1'b1);
    repeat (200) @(negedge clk);
    chk("R10 bclks per run mod RC", (rises - r0) % RC, 0);
    chk("R10 bclks per run mod PB", (rises - r0) % PB, 0);
    chk("R10 run nonempty", (rises - r0) > 0, 1);
    chk("R5 stopped clocks low", {bclk_o, pbfrm_o, recfrm_o}, 3'b000);

    // R2 writes without strobe are ignored
    set_cfg(4'b0100, 2'b01, 1'b1);
    repeat (100) @(negedge clk);
    ctl_wdata = 16'hF000;
    repeat (5) @(negedge clk);
    chk("R2 no-strobe write ignored", {bclk_oe, pbfrm_oe, recfrm_oe, sdout_oe}, 4'b1111);
    ctl_wdata = '0;

    chk("R10 bclk truncated phases", viol_b, 0);
    chk("R10 pbfrm truncated phases", viol_p, 0);
    chk("R10 recfrm truncated phases", viol_r, 0);

    // R1 reset while running
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-run oe", {bclk_oe, pbfrm_oe, recfrm_oe, sdout_oe}, 4'b0001);
    chk("R1 reset mid-run clocks", {bclk_o, pbfrm_o, recfrm_o}, 3'b000);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 control zero after reset", {bclk_o, pbfrm_o, bclk_oe}, 3'b000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule